// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block drives a linear CCD sensor from a fast system clock. For each line it produces a readout-gate pulse that moves the charge into the sensor's shift register, with a quiet guard interval on either side. It then sends exactly one full line of pixel shift clocks. Each line has 2631 shift-clock periods: 33 leading dummy pixels, 2592 effective pixels and 6 trailing dummy pixels. When the sensor is run in external-reset mode, the block also drives a short reset pulse inside each pixel at a fixed offset from the shift-clock rising edge. In internal-reset mode it holds that output low.

All timing is counted in system-clock cycles. Parameters set the half period of the shift clock, the gate width, the guard length and the placement of the reset pulse. Elaboration stops with an error when a parameter set breaks the sensor's minimums: a 200 ns pixel period, a 500 ns gate and guard, and a 50 ns reset width with 50 ns of clearance before the next clock edge. The shift clock always has a 50 % duty cycle. A pixel index, an effective-pixel flag and a one-cycle end-of-line strobe follow the shift clock, so that a capture path can tag each sample.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is held, shift_clk is 1, and gate_pulse, rst_pulse, pix_idx, pix_active and line_done are all 0.
- R2: A line starts only from idle with enable high. It opens with GUARD cycles in which shift_clk is 1 and gate_pulse is 0.
- R3: gate_pulse is 1 for exactly ROG_W consecutive cycles per line, and shift_clk stays 1 during all of them.
- R4: After gate_pulse falls, shift_clk stays 1 for exactly GUARD cycles before its first fall.
- R5: Each line carries exactly 2631 shift_clk periods. Each period is HALF_DIV cycles at 0 followed by HALF_DIV cycles at 1.
- R6: pix_idx equals the number of the current shift-clock period (0 to 2630). It advances by one when shift_clk falls, and it is 0 outside the shift phase.
- R7: pix_active is 1 exactly while pix_idx is in 33..2624 (2592 effective pixels) during the shift phase.
- R8: line_done is 1 for one cycle, in the last cycle of the high half of period 2630.
- R9: When enable is low at the end of a line, the block goes idle with all outputs at their reset values. When enable is high there, the next line's guard begins in the next cycle. Dropping enable mid-line does not shorten the line.
- R10: With ext_rs_mode = 1, rst_pulse is 1 for RS_W cycles per period, starting RS_DLY cycles after shift_clk rises, and it ends at least 50 ns before shift_clk falls.
- R11: With ext_rs_mode = 0, rst_pulse stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run lines back to back while high |
| ext_rs_mode | input | 1 | 1 selects external-reset mode |
| shift_clk | output | 1 | Pixel shift clock to the sensor |
| gate_pulse | output | 1 | Readout-gate pulse, active high |
| rst_pulse | output | 1 | Reset pulse for external-reset mode |
| pix_idx | output | IW | Current pixel period number |
| pix_active | output | 1 | Current pixel is an effective pixel |
| line_done | output | 1 | One-cycle end-of-line strobe |

## Verification
The bench follows three lines cycle by cycle against a time-since-line-start model. The first two run back to back, and the mode switches from internal to external between them. A counter that stopped one period short or long would move line_done and misplace the next gate, and the model would catch this at once. An off-by-one in the guard or gate counter would shift every later edge. A wrong end of the effective window would show at pixel 33 or 2625. Dropping enable mid-line checks that the line still runs to completion and does not stop early. A reset window placed in the wrong half-period, or one left enabled in internal mode, shows up as an rst_pulse mismatch.

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int SYS_NS   = 10,
  parameter int HALF_DIV = 10,
  parameter int ROG_W    = 100,
  parameter int GUARD    = 100,
  parameter int RS_DLY   = 0,
  parameter int RS_W     = 5,
  parameter int LEAD     = 33,
  parameter int ACTIVE   = 2592,
  parameter int TRAIL    = 6,
  localparam int LINE    = LEAD + ACTIVE + TRAIL,
  localparam int IW      = $clog2(LINE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          ext_rs_mode,
  output logic          shift_clk,
  output logic          gate_pulse,
  output logic          rst_pulse,
  output logic [IW-1:0] pix_idx,
  output logic          pix_active,
  output logic          line_done
);

  localparam int PER  = 2 * HALF_DIV;
  localparam int MX0  = (PER > ROG_W) ? PER : ROG_W;
  localparam int MXV  = (MX0 > GUARD) ? MX0 : GUARD;
  localparam int CW   = $clog2(MXV + 1);

  localparam logic [CW-1:0] C_GUARD = CW'(GUARD - 1);
  localparam logic [CW-1:0] C_GATE  = CW'(ROG_W - 1);
  localparam logic [CW-1:0] C_PER   = CW'(PER - 1);
  localparam logic [CW-1:0] C_HALF  = CW'(HALF_DIV);
  localparam logic [CW-1:0] C_RS_ON = CW'(HALF_DIV + RS_DLY);
  localparam logic [CW-1:0] C_RS_OF = CW'(HALF_DIV + RS_DLY + RS_W);
  localparam logic [IW-1:0] P_LAST  = IW'(LINE - 1);
  localparam logic [IW-1:0] P_LO    = IW'(LEAD);
  localparam logic [IW-1:0] P_HI    = IW'(LEAD + ACTIVE);

  if (HALF_DIV < 1 || PER * SYS_NS < 200) begin : g_bad_div
    $error("shift clock period below 200 ns");
  end
  if (ROG_W * SYS_NS < 500 || GUARD * SYS_NS < 500) begin : g_bad_gate
    $error("gate width or guard below 500 ns");
  end
  if (RS_DLY < 0 || RS_W * SYS_NS < 50 ||
      (HALF_DIV - RS_DLY - RS_W) * SYS_NS < 50) begin : g_bad_rs
    $error("reset pulse placement breaks 50 ns limits");
  end

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GATE, S_POST, S_RUN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      pix <= '0;
    end else begin
      case (st)
        S_IDLE: if (enable) begin
          st  <= S_PRE;
          cnt <= '0;
        end
        S_PRE: if (cnt == C_GUARD) begin
          st  <= S_GATE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_GATE: if (cnt == C_GATE) begin
          st  <= S_POST;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_POST: if (cnt == C_GUARD) begin
          st  <= S_RUN;
          cnt <= '0;
          pix <= '0;
        end else cnt <= cnt + 1'b1;
        S_RUN: if (cnt == C_PER) begin
          cnt <= '0;
          if (pix == P_LAST) begin
            pix <= '0;
            st  <= enable ? S_PRE : S_IDLE;
          end else pix <= pix + 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire run = (st == S_RUN);

  assign shift_clk  = !run || (cnt >= C_HALF);
  assign gate_pulse = (st == S_GATE);
  assign rst_pulse  = ext_rs_mode && run && (cnt >= C_RS_ON) && (cnt < C_RS_OF);
  assign pix_idx    = pix;
  assign pix_active = run && (pix >= P_LO) && (pix < P_HI);
  assign line_done  = run && (pix == P_LAST) && (cnt == C_PER);

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
  parameter int LEAD   = 33,
  parameter int ACTIVE = 2592,
  parameter int TRAIL  = 6,
  localparam int LINE  = LEAD + ACTIVE + TRAIL,
  localparam int IW    = $clog2(LINE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          ext_rs_mode,
  input logic          shift_clk,
  input logic          gate_pulse,
  input logic          rst_pulse,
  input logic [IW-1:0] pix_idx,
  input logic          pix_active,
  input logic          line_done
);

  a_r3_gate_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    gate_pulse |-> shift_clk);

  a_r4_clk_held_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_pulse) |-> shift_clk);

  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_idx != $past(pix_idx)) |->
      (pix_idx == $past(pix_idx) + 1'b1) || (pix_idx == '0));

  a_r7_active_window: assert property (@(posedge clk) disable iff (!rst_n)
    pix_active |-> (int'(pix_idx) >= LEAD) && (int'(pix_idx) < LEAD + ACTIVE));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  a_r8_done_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> shift_clk && (int'(pix_idx) == LINE - 1));

  a_r9_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !enable) |=> shift_clk && !gate_pulse && (pix_idx == '0));

  a_r10_rs_in_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> shift_clk);

  a_r11_rs_low_internal: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rs_mode |-> !rst_pulse);

endmodule

bind ccd_line_timer ccd_line_timer_chk #(
  .LEAD(LEAD), .ACTIVE(ACTIVE), .TRAIL(TRAIL)
) u_chk (.*);

// File: tb/sim_ccd_line_timer.sv
`timescale 1ns/1ps
module sim_ccd_line_timer;
  localparam int CLK_PERIOD = 25;
  localparam int HD = 4, PER = 8, W = 20, G = 20, DLY = 0, RSW = 2;
  localparam int NPIX = 2631;
  localparam int L = 2 * G + W + NPIX * PER;

  logic clk = 0, rst_n = 0, en = 0, mode = 0;
  logic shift_clk, gate_pulse, rst_pulse, pix_active, line_done;
  logic [11:0] pix_idx;

  int checks = 0, errors = 0, cycles = 0;
  int act = 0, t = 0, run_chk = 0, rises = 0;
  logic prev_clk = 1;

  ccd_line_timer #(.SYS_NS(CLK_PERIOD), .HALF_DIV(HD), .ROG_W(W), .GUARD(G),
                   .RS_DLY(DLY), .RS_W(RSW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .ext_rs_mode(mode),
    .shift_clk(shift_clk), .gate_pulse(gate_pulse), .rst_pulse(rst_pulse),
    .pix_idx(pix_idx), .pix_active(pix_active), .line_done(line_done));

  always #(CLK_PERIOD/2.0) clk = ~clk;

  task automatic chk(input string tag, input int a, input int e);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at t=%0d time %0t", tag, a, e, t, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    if (!rst_n) begin act = 0; t = 0; end
    else if (act == 0) begin if (en) begin act = 1; t = 0; end end
    else if (t == L - 1) begin if (!en) act = 0; t = 0; end
    else t++;
  end

  always @(negedge clk) if (rst_n && run_chk != 0) begin
    int ec, eg, er, ep, ea, ed, r, p, ph;
    string ctag;
    ec = 1; eg = 0; er = 0; ep = 0; ea = 0; ed = 0; ctag = "R9";
    if (act != 0) begin
      if (t < G) ctag = "R2";
      else if (t < G + W) begin ctag = "R3"; eg = 1; end
      else if (t < 2 * G + W) ctag = "R4";
      else begin
        ctag = "R5";
        r = t - (2 * G + W); p = r / PER; ph = r % PER;
        ec = (ph >= HD) ? 1 : 0;
        ep = p;
        ea = (p >= 33 && p < 2625) ? 1 : 0;
        ed = (p == NPIX - 1 && ph == PER - 1) ? 1 : 0;
        er = (mode && ph >= HD + DLY && ph < HD + DLY + RSW) ? 1 : 0;
      end
      if (t == 0) rises = 0;
      else if (shift_clk && !prev_clk) rises++;
      if (t == L - 1) chk("R5 period count", rises, NPIX);
    end
    chk({ctag, " shift_clk"}, int'(shift_clk), ec);
    chk("R3 gate_pulse", int'(gate_pulse), eg);
    chk(mode ? "R10 rst_pulse" : "R11 rst_pulse", int'(rst_pulse), er);
    chk("R6 pix_idx", int'(pix_idx), ep);
    chk("R7 pix_active", int'(pix_active), ea);
    chk("R8 line_done", int'(line_done), ed);
    prev_clk = shift_clk;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 shift_clk", int'(shift_clk), 1);
    chk("R1 gate_pulse", int'(gate_pulse), 0);
    chk("R1 rst_pulse", int'(rst_pulse), 0);
    chk("R1 pix_idx", int'(pix_idx), 0);
    chk("R1 pix_active", int'(pix_active), 0);
    chk("R1 line_done", int'(line_done), 0);
    rst_n = 1; run_chk = 1;
    repeat (30) @(negedge clk);
    en = 1;
    @(negedge clk);
    while (!(act != 0 && t == L - 1)) @(negedge clk);
    @(negedge clk);
    chk("R9 back-to-back start", act * 1000 + t, 1000);
    mode = 1;
    while (!(act != 0 && t == 5000)) @(negedge clk);
    en = 0;
    while (act != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    en = 1;
    repeat (5) @(negedge clk);
    en = 0;
    while (act != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule